// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This peripheral holds three identical 32-bit counters behind a small register file. Each counter is driven either by the bus clock or by rising edges of one external tick input. It counts down by default, or up when a global direction bit is set. On passing its end value it reloads from its own load register, so it can produce periodic events. With a reload value of all ones it runs free.

Each channel compares its count against two match registers. Any arrival at a match value, and any wrap, raises a bit in a sticky status register. Status bits are cleared by writing ones to them. A mask register selects which status bits reach the single interrupt output.

Software arms a one-shot event by reading the count and writing `count - delta` into a match register. Small deltas such as 4 bus cycles work because the match check runs on every step. The external tick is synchronised and edge-detected inside the block.

Each cycle, every channel takes exactly one of four step kinds:

| Step kind | When it applies | Effect on the count |
|---|---|---|
| HOLD | the channel is disabled, or no tick arrived | keeps its value |
| WRITE | software writes the count register | takes the written value; this wins over everything else |
| STEP | a tick arrives and the count is not at its end value | moves one step (down, or up when the direction bit is set) |
| WRAP | a tick arrives and the count is at its end value (0 when counting down, all ones when counting up) | reloads from the load register |

Top module: `triple_timer`

## Requirements
- R1: Register byte offsets are fixed as follows.
  - Channel n (0..2) has its bank at 0x10·n: count at +0x0, load at +0x4, first match at +0x8, second match at +0xC.
  - Control is at 0x30, status at 0x34 and mask at 0x38.
  - Every register resets to zero.
  - A read returns the addressed register on `rdata` one clock after `addr` is presented.
- R2: Control bits 3n, 3n+1 and 3n+2 are channel n's enable, clock source and wrap-interrupt enable. With enable=1 and source=0, the count changes by exactly one on every bus clock.
- R3: When control bit 9 is 0, counting is downward. A step taken from a count of 0 loads the load register value instead of decrementing.
- R4: When control bit 9 is 1, every channel counts upward. A step taken from a count of all ones loads the load register value.
- R5: A step or wrap that makes the count equal to a match register sets that channel's match status bit. For channel n these are bit 3n (first match) and bit 3n+1 (second match). This works for a match set 4 below the running count.
- R6: A wrap sets status bit 3n+2 only while that channel's wrap-interrupt enable bit is 1. With the enable bit at 0, a wrap leaves status unchanged.
- R7: With source=1, the channel steps once per rising edge of `ext_tick`. The edge is seen after a two-flop synchroniser, and the channel ignores bus clock cycles.
- R8: A disabled channel holds its count. Enabling it again resumes from the held value.
- R9: A software write to a count register takes effect even while the channel runs, and overrides that cycle's step.
- R10: Writing 1 to a status bit clears it. A new event in the same cycle wins over the clear.
- R11: `irq` is high exactly when some status bit is 1 while its mask bit is 0. The mask does not change the status value that is read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | bus clock |
| rst_n | input | 1 | active-low synchronous reset |
| wr_en | input | 1 | write strobe for the register at `addr` |
| addr | input | 6 | byte address of the register |
| wdata | input | 32 | write data |
| rdata | output | 32 | registered read data for the previous cycle's `addr` |
| ext_tick | input | 1 | asynchronous external tick source |
| irq | output | 1 | combined unmasked interrupt |

## Verification
Properties checked on every cycle:
- a disabled channel with no write keeps its count;
- a running down-counter decrements by one, and wraps from zero to its load value;
- the synchronised tick is a single-cycle pulse;
- a wrap status bit never rises unless its enable bit was set;
- a write-one clear with no competing event empties the bit.

The bench scenarios cover what needs a whole sequence of steps:
- exact counts after a known number of steps;
- match hits, including a delta of 4;
- up-count wrap;
- external-edge counting through the synchroniser;
- resume after hold;
- masking of the interrupt;
- a count write that overrides a running channel.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int TMR_AW   = 6;
    localparam int BITS_PER = 3;
    localparam int F_EN     = 0;
    localparam int F_SRC    = 1;
    localparam int F_IE     = 2;
    localparam int R_COUNT  = 0;
    localparam int R_LOAD   = 1;
    localparam int R_MATCHA = 2;
    localparam int R_MATCHB = 3;
    localparam int CTL_BANK = 3;
    localparam int R_CTRL   = 0;
    localparam int R_STAT   = 1;
    localparam int R_MASK   = 2;

    typedef enum logic [1:0] {
        SK_HOLD,
        SK_WRITE,
        SK_STEP,
        SK_WRAP
    } step_kind_t;

    function automatic logic [TMR_AW-1:0] reg_off(input int bank, input int sel);
        logic [TMR_AW-1:0] a;
        a = '0;
        a[5:4] = 2'(bank);
        a[3:2] = 2'(sel);
        return a;
    endfunction
endpackage

// File: rtl/tmr_tick_sync.sv
module tmr_tick_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_async,
    output logic tick_pulse
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], tick_async};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign tick_pulse = sync_q[STAGES-1] & ~prev_q;

    // R7: an edge yields exactly one step pulse
    a_r7_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tick_pulse |=> !tick_pulse);
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan import tmr_pkg::*; #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             src_ext,
    input  logic             up,
    input  logic             ext_step,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic [CNT_W-1:0] load,
    input  logic [CNT_W-1:0] match_a,
    input  logic [CNT_W-1:0] match_b,
    output logic [CNT_W-1:0] cnt,
    output logic             evt_a,
    output logic             evt_b,
    output logic             evt_wrap
);
    localparam logic [CNT_W-1:0] ALL1 = '1;

    step_kind_t       kind;
    logic             tick;
    logic [CNT_W-1:0] cnt_nxt;

    assign tick = en & (src_ext ? ext_step : 1'b1);

    always_comb begin
        if (cnt_we)                          kind = SK_WRITE;
        else if (!tick)                      kind = SK_HOLD;
        else if (up ? (cnt == ALL1) : (cnt == '0)) kind = SK_WRAP;
        else                                 kind = SK_STEP;
    end

    always_comb begin
        unique case (kind)
            SK_WRITE: cnt_nxt = cnt_wdata;
            SK_WRAP:  cnt_nxt = load;
            SK_STEP:  cnt_nxt = up ? cnt + 1'b1 : cnt - 1'b1;
            default:  cnt_nxt = cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt_nxt;
    end

    always_comb begin
        evt_wrap = (kind == SK_WRAP);
        evt_a    = ((kind == SK_STEP) || (kind == SK_WRAP)) && (cnt_nxt == match_a);
        evt_b    = ((kind == SK_STEP) || (kind == SK_WRAP)) && (cnt_nxt == match_b);
    end

    // R8: disabled and unwritten count is frozen
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !cnt_we) |=> $stable(cnt));
    // R2: bus-clock down step moves by one
    a_r2_down_step: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !src_ext && !up && !cnt_we && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
    // R3: down wrap from zero takes the load value
    a_r3_wrap_load: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !src_ext && !up && !cnt_we && cnt == '0) |=> (cnt == $past(load)));
endmodule

// File: rtl/triple_timer.sv
module triple_timer import tmr_pkg::*; #(
    parameter int CNT_W       = 32,
    parameter int NCH         = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [TMR_AW-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    input  logic              ext_tick,
    output logic              irq
);
    localparam int SW = BITS_PER * NCH;
    localparam int CW = SW + 1;
    localparam int UP_BIT = SW;

    logic [CW-1:0]    ctrl_q;
    logic [SW-1:0]    stat_q, mask_q, set_v, clr_v;
    logic [CNT_W-1:0] load_q [NCH];
    logic [CNT_W-1:0] ma_q   [NCH];
    logic [CNT_W-1:0] mb_q   [NCH];
    logic [CNT_W-1:0] cnt_w  [NCH];
    logic             ext_step;
    logic [CNT_W-1:0] rd_mux;

    tmr_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .tick_async(ext_tick), .tick_pulse(ext_step)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic ea, eb, ew;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                load_q[g] <= '0;
                ma_q[g]   <= '0;
                mb_q[g]   <= '0;
            end else if (wr_en) begin
                if (addr == reg_off(g, R_LOAD))   load_q[g] <= wdata;
                if (addr == reg_off(g, R_MATCHA)) ma_q[g]   <= wdata;
                if (addr == reg_off(g, R_MATCHB)) mb_q[g]   <= wdata;
            end
        end

        tmr_chan #(.CNT_W(CNT_W)) u_chan (
            .clk(clk), .rst_n(rst_n),
            .en(ctrl_q[BITS_PER*g+F_EN]),
            .src_ext(ctrl_q[BITS_PER*g+F_SRC]),
            .up(ctrl_q[UP_BIT]),
            .ext_step(ext_step),
            .cnt_we(wr_en && addr == reg_off(g, R_COUNT)),
            .cnt_wdata(wdata),
            .load(load_q[g]), .match_a(ma_q[g]), .match_b(mb_q[g]),
            .cnt(cnt_w[g]), .evt_a(ea), .evt_b(eb), .evt_wrap(ew)
        );

        assign set_v[BITS_PER*g]   = ea;
        assign set_v[BITS_PER*g+1] = eb;
        assign set_v[BITS_PER*g+2] = ew & ctrl_q[BITS_PER*g+F_IE];

        // R6: wrap status rises only with the enable bit set
        a_r6_wrap_gated: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(stat_q[BITS_PER*g+2]) |-> $past(ctrl_q[BITS_PER*g+F_IE]));
    end

    assign clr_v = (wr_en && addr == reg_off(CTL_BANK, R_STAT)) ? wdata[SW-1:0] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            stat_q <= '0;
            mask_q <= '0;
        end else begin
            stat_q <= (stat_q & ~clr_v) | set_v;
            if (wr_en && addr == reg_off(CTL_BANK, R_CTRL)) ctrl_q <= wdata[CW-1:0];
            if (wr_en && addr == reg_off(CTL_BANK, R_MASK)) mask_q <= wdata[SW-1:0];
        end
    end

    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NCH; i++) begin
            if (addr == reg_off(i, R_COUNT))  rd_mux = cnt_w[i];
            if (addr == reg_off(i, R_LOAD))   rd_mux = load_q[i];
            if (addr == reg_off(i, R_MATCHA)) rd_mux = ma_q[i];
            if (addr == reg_off(i, R_MATCHB)) rd_mux = mb_q[i];
        end
        if (addr == reg_off(CTL_BANK, R_CTRL)) rd_mux = CNT_W'(ctrl_q);
        if (addr == reg_off(CTL_BANK, R_STAT)) rd_mux = CNT_W'(stat_q);
        if (addr == reg_off(CTL_BANK, R_MASK)) rd_mux = CNT_W'(mask_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= rd_mux;
    end

    assign irq = |(stat_q & ~mask_q);

    for (genvar k = 0; k < SW; k++) begin : g_w1c
        // R10: clear with no competing event empties the bit
        a_r10_w1c: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_v[k] && !set_v[k]) |=> !stat_q[k]);
    end
endmodule

// File: tb/tb_triple_timer.sv
module tb_triple_timer;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        ext_tick = 0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
        int          stamp;
    } item_t;
    item_t sb[$];

    triple_timer dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ext_tick(ext_tick), .irq(irq)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compare registered read data one cycle after the request
    always @(negedge clk) begin
        if (sb.size() > 0 && sb[0].stamp < cyc) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (rdata !== it.exp) begin
                errors++;
                $display("FAIL %s actual=%h expected=%h", it.tag, rdata, it.exp);
            end
        end
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        addr = a;
        it.exp = e; it.tag = tag; it.stamp = cyc;
        sb.push_back(it);
    endtask

    task automatic chk_irq(input logic e, input string tag);
        @(negedge clk);
        checks++;
        if (irq !== e) begin
            errors++;
            $display("FAIL %s irq actual=%b expected=%b", tag, irq, e);
        end
    endtask

    // enable, wait k negedges, disable: channels step k+2 times
    task automatic run(input logic [31:0] ctl, input int k);
        wr(6'h30, ctl);
        repeat (k) @(negedge clk);
        wr(6'h30, ctl & 32'h200);
    endtask

    task automatic drain();
        while (sb.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd(6'h30, 0, "R1 ctrl reset");
        rd(6'h34, 0, "R1 status reset");
        rd(6'h00, 0, "R1 count0 reset");
        rd(6'h38, 0, "R1 mask reset");
        drain();
        chk_irq(0, "R11 irq reset");

        // R2/R5: ch0 down 20 -> 10, passes match 12
        wr(6'h04, 50); wr(6'h08, 12); wr(6'h0C, 100); wr(6'h00, 20);
        run(32'h005, 8);
        rd(6'h00, 10, "R2 count after 10 steps");
        rd(6'h34, 32'h001, "R5 match status ch0");
        rd(6'h08, 12, "R1 match register offset");
        drain();
        chk_irq(1, "R11 irq on unmasked status");
        wr(6'h38, 32'h001);
        chk_irq(0, "R11 mask blocks irq");
        rd(6'h34, 32'h001, "R11 mask keeps status");
        wr(6'h34, 32'h001);
        rd(6'h34, 0, "R10 write-one clear");
        wr(6'h38, 0);
        drain();

        // R3/R6: wrap with interrupt enable: 10->0->50->49->48
        run(32'h005, 11);
        rd(6'h00, 48, "R3 reload after wrap");
        rd(6'h34, 32'h004, "R6 wrap status with enable");
        wr(6'h34, 32'h1FF);
        // R6: wrap without enable leaves status
        wr(6'h00, 2);
        run(32'h001, 2);
        rd(6'h00, 49, "R3 wrap count no enable");
        rd(6'h34, 0, "R6 wrap ignored without enable");
        drain();

        // R4: ch1 up count FD->FE->FF->7->8
        wr(6'h14, 7); wr(6'h18, 32'hFFFF_FFFF); wr(6'h1C, 8);
        wr(6'h10, 32'hFFFF_FFFD);
        run(32'h228, 2);
        rd(6'h10, 8, "R4 up count wrap reload");
        rd(6'h34, 32'h038, "R4 up match and wrap status");
        rd(6'h1C, 8, "R1 ch1 second match offset");
        wr(6'h30, 0);
        wr(6'h34, 32'h1FF);

        // R5: one-shot with delta 4 on ch2
        wr(6'h24, 32'hFFFF_FFFF); wr(6'h20, 1000); wr(6'h28, 996);
        run(32'h040, 2);
        rd(6'h20, 996, "R5 delta 4 count");
        rd(6'h34, 32'h040, "R5 delta 4 match status");
        drain();
        wr(6'h34, 32'h1FF);

        // R7: external ticks on ch0
        wr(6'h00, 100);
        wr(6'h30, 32'h003);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk) ext_tick = 1;
            repeat (3) @(negedge clk);
            ext_tick = 0;
            repeat (3) @(negedge clk);
        end
        repeat (8) @(negedge clk);
        wr(6'h30, 0);
        rd(6'h00, 95, "R7 five external edges");
        // R8 hold and resume
        repeat (20) @(negedge clk);
        rd(6'h00, 95, "R8 disabled holds");
        run(32'h001, 0);
        rd(6'h00, 93, "R8 resume from held value");

        // R9: write count while running
        wr(6'h30, 32'h001);
        wr(6'h00, 500);
        wr(6'h30, 0);
        rd(6'h00, 498, "R9 running count write");
        rd(6'h34, 0, "R6 no status from ch0 steps");
        drain();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule